// File: doc/BRIEF.md
# Inter-processor mailbox with interrupt banks

This block lets several processors pass 32-bit messages to each other through a set of independent mailboxes. Each mailbox is a small first-in first-out queue behind one register address: storing to that address queues a word, and loading from it removes the oldest word. Two further read-only registers per mailbox give the number of words queued and whether the queue is full.

Every processor (a "user") owns one interrupt bank. It has a status register that collects two events per mailbox, new word arrived and space freed, and an enable register that selects which events drive that user's interrupt line. Status bits are acknowledged by writing ones. A configuration register starts a short self-clearing soft reset that empties every queue and clears every bank. A status register reports when that reset has finished. A revision register identifies the block. The register port is a plain single-cycle read/write port, and read data is registered.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to address 0x040+4*m pushes the 32-bit word into mailbox m. A read of that address returns and removes the oldest word, so words leave in the order they were written.
- R2: A write to a full mailbox is dropped and leaves its contents and count unchanged. A read of an empty mailbox returns 0 and changes nothing.
- R3: Address 0x0C0+4*m reads the number of words held in mailbox m, where 0 means empty. Address 0x080+4*m reads 1 when mailbox m is full and 0 otherwise.
- R4: Every accepted push into mailbox m sets bit 2*m in the status register of every user. A pop that leaves a previously full mailbox m non-full sets bit 2*m+1. A pop from a mailbox that was not full sets no not-full bit.
- R5: The status register of user u is at 0x100+8*u. Writing it clears each bit written as 1 and keeps each bit written as 0.
- R6: The enable register of user u is at 0x104+8*u and reads back what was written. irq_out[u] is high, one cycle after the registers change, exactly when enable AND status of user u is nonzero.
- R7: Writing 1 to bit 1 of address 0x010 starts a soft reset. For RST_CYCLES cycles, bit 1 of 0x010 reads 1 and bit 0 of 0x014 reads 0. During that window, every mailbox is emptied and every status and enable bit is cleared. Afterwards bit 1 reads 0 and bit 0 of 0x014 reads 1.
- R8: Address 0x000 reads the major version in bits 7:4 and the minor version in bits 3:0. The default is 0x21.
- R9: After the synchronous reset input, all mailboxes are empty, all status and enable bits are 0, all interrupt lines are low, read data is 0 and bit 0 of 0x014 reads 1.
- R10: A read of an address that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle after the read strobe |
| irq_out | output | USER_N | Interrupt line per user |

## Verification
The hardest conditions to reach are the not-full event and the soft-reset window. A not-full event needs a mailbox filled to capacity and then exactly one pop, so the bench fills a queue, clears the status bank and checks the bit after the first pop. It then acknowledges the bit and checks that a second pop does not raise it again. The soft-reset window lasts only a few cycles, so the bench issues back-to-back reads of the configuration and status registers immediately after starting it. It then polls for the done flag and confirms that the queues, status bits and enables that were loaded beforehand are all cleared.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int MBOX_N_DEF  = 4;
  localparam int FIFO_D_DEF  = 4;
  localparam int USER_N_DEF  = 4;
  localparam int DATA_W_DEF  = 32;
  localparam int ADDR_W      = 10;
  localparam int REV_MAJ_DEF = 2;
  localparam int REV_MIN_DEF = 1;

  localparam logic [ADDR_W-1:0] OFS_REV    = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 10'h014;
  localparam logic [ADDR_W-1:0] OFS_MSG    = 10'h040;
  localparam logic [ADDR_W-1:0] OFS_FULL   = 10'h080;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 10'h0C0;
  localparam logic [ADDR_W-1:0] OFS_IRQST  = 10'h100;
  localparam logic [ADDR_W-1:0] OFS_IRQEN  = 10'h104;

  function automatic logic [ADDR_W-1:0] reg_ofs(input logic [ADDR_W-1:0] base,
                                                input int idx, input int stride);
    reg_ofs = base + ADDR_W'(idx * stride);
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              push_ok,
  output logic              nf_evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign nf_evt  = pop_ok && full;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  // R2: the count never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  // R2: a push into a full queue leaves the count alone
  p_drop_full_r2: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full && !clr) |=> $stable(count));
  // R2: a pop from an empty queue leaves the count alone
  p_empty_pop_r2: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty && !clr) |=> (count == '0));
endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank #(
  parameter int EV_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [EV_W-1:0] evt,
  input  logic            st_we,
  input  logic            en_we,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] status,
  output logic [EV_W-1:0] enable,
  output logic            irq
);
  logic [EV_W-1:0] ack;

  assign ack = st_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~ack) | evt;
      if (en_we) enable <= wdata;
      irq    <= |(enable & status);
    end
  end

  // R5: acknowledged bits are zero afterwards unless an event raced them
  p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (st_we && !clr && ((wdata & evt) == '0)) |=> ((status & $past(wdata)) == '0));
  // R6: with nothing enabled the line stays low
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (enable == '0) |=> !irq);
  // R4: a raised event is visible in the next cycle
  p_evt_set_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && (evt != '0)) |=> ((status & $past(evt)) == $past(evt)));
endmodule

// File: rtl/mbox_sysctl.sv
module mbox_sysctl #(
  parameter int RST_CYCLES = 4,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= CW'(RST_CYCLES - 1);
    end
  end

  // R7: done is never shown while the reset is running
  p_busy_notdone_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  // R7: the end of the window raises done
  p_done_after_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int MBOX_N     = MBOX_N_DEF,
  parameter int FIFO_D     = FIFO_D_DEF,
  parameter int USER_N     = USER_N_DEF,
  parameter int DATA_W     = DATA_W_DEF,
  parameter int RST_CYCLES = 4,
  parameter int REV_MAJ    = REV_MAJ_DEF,
  parameter int REV_MIN    = REV_MIN_DEF,
  localparam int EV_W      = 2 * MBOX_N,
  localparam int CNT_W     = $clog2(FIFO_D + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [USER_N-1:0] irq_out
);
  logic [MBOX_N-1:0] push, pop, full, empty, push_ok, nf_evt;
  logic [DATA_W-1:0] head [MBOX_N];
  logic [CNT_W-1:0]  cnt  [MBOX_N];
  logic [USER_N-1:0] st_we, en_we;
  logic [EV_W-1:0]   ust [USER_N];
  logic [EV_W-1:0]   uen [USER_N];
  logic [EV_W-1:0]   evt;
  logic              sr_start, sr_busy, sr_done;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_acc, rd_acc;

  assign wr_acc = bus_en && bus_wr;
  assign rd_acc = bus_en && !bus_wr;

  always_comb begin
    for (int m = 0; m < MBOX_N; m++) begin
      evt[2*m]   = push_ok[m];
      evt[2*m+1] = nf_evt[m];
    end
  end

  always_comb begin
    push     = '0;
    pop      = '0;
    st_we    = '0;
    en_we    = '0;
    sr_start = wr_acc && (bus_addr == OFS_CFG) && bus_wdata[1];
    rd_mux   = '0;
    if (bus_addr == OFS_REV)
      rd_mux = DATA_W'({4'(REV_MAJ), 4'(REV_MIN)});
    if (bus_addr == OFS_CFG)
      rd_mux = DATA_W'({sr_busy, 1'b0});
    if (bus_addr == OFS_STAT)
      rd_mux = DATA_W'(sr_done);
    for (int m = 0; m < MBOX_N; m++) begin
      if (bus_addr == reg_ofs(OFS_MSG, m, 4)) begin
        push[m] = wr_acc;
        pop[m]  = rd_acc;
        rd_mux  = empty[m] ? '0 : head[m];
      end
      if (bus_addr == reg_ofs(OFS_FULL, m, 4))
        rd_mux = DATA_W'(full[m]);
      if (bus_addr == reg_ofs(OFS_CNT, m, 4))
        rd_mux = DATA_W'(cnt[m]);
    end
    for (int u = 0; u < USER_N; u++) begin
      if (bus_addr == reg_ofs(OFS_IRQST, u, 8)) begin
        st_we[u] = wr_acc;
        rd_mux   = DATA_W'(ust[u]);
      end
      if (bus_addr == reg_ofs(OFS_IRQEN, u, 8)) begin
        en_we[u] = wr_acc;
        rd_mux   = DATA_W'(uen[u]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end

  for (genvar m = 0; m < MBOX_N; m++) begin : g_mbox
    mbox_fifo #(.DEPTH(FIFO_D), .DATA_W(DATA_W)) i_fifo (
      .clk(clk), .rst(rst), .clr(sr_busy),
      .push(push[m]), .pop(pop[m]), .din(bus_wdata),
      .dout(head[m]), .count(cnt[m]), .full(full[m]), .empty(empty[m]),
      .push_ok(push_ok[m]), .nf_evt(nf_evt[m])
    );
  end

  for (genvar u = 0; u < USER_N; u++) begin : g_user
    mbox_irq_bank #(.EV_W(EV_W)) i_bank (
      .clk(clk), .rst(rst), .clr(sr_busy), .evt(evt),
      .st_we(st_we[u]), .en_we(en_we[u]), .wdata(bus_wdata[EV_W-1:0]),
      .status(ust[u]), .enable(uen[u]), .irq(irq_out[u])
    );
  end

  mbox_sysctl #(.RST_CYCLES(RST_CYCLES)) i_sysctl (
    .clk(clk), .rst(rst), .start(sr_start), .busy(sr_busy), .done(sr_done)
  );

  // R1: a push into a queue with room always raises its new-word event
  p_push_event_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && !sr_busy && (bus_addr == OFS_MSG) && !full[0]) |-> evt[0]);
  // R7: the soft reset leaves every queue empty
  p_sr_empty_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_busy) |-> (empty == '1));
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NU = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_en = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NU-1:0] irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [AW-1:0] a_msg(int m);  return AW'(12'h040 + 4*m); endfunction
  function automatic logic [AW-1:0] a_full(int m); return AW'(12'h080 + 4*m); endfunction
  function automatic logic [AW-1:0] a_cnt(int m);  return AW'(12'h0C0 + 4*m); endfunction
  function automatic logic [AW-1:0] a_st(int u);   return AW'(12'h100 + 8*u); endfunction
  function automatic logic [AW-1:0] a_en(int u);   return AW'(12'h104 + 8*u); endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R9 rdata after reset", bus_rdata, 0);
    check("R9 irq after reset", DW'(irq_out), 0);
    for (int m = 0; m < 4; m++) begin
      rd(a_cnt(m), d); check("R9 count after reset", d, 0);
    end
    rd(a_full(0), d); check("R9 full flag after reset", d, 0);
    rd(a_st(2), d);   check("R9 status after reset", d, 0);
    rd(a_en(3), d);   check("R9 enable after reset", d, 0);
    rd(10'h014, d);   check("R9 done after reset", d, 1);
    rd(10'h000, d);   check("R8 revision", d, 32'h21);
  endtask

  task automatic t_order();
    logic [DW-1:0] d;
    wr(a_msg(1), 32'hA000_0001);
    wr(a_msg(1), 32'hB000_0002);
    wr(a_msg(1), 32'hC000_0003);
    rd(a_cnt(1), d); check("R3 count three", d, 3);
    rd(a_full(1), d); check("R3 not full at three", d, 0);
    rd(a_cnt(0), d); check("R1 other queue untouched", d, 0);
    rd(a_msg(1), d); check("R1 first out", d, 32'hA000_0001);
    rd(a_msg(1), d); check("R1 second out", d, 32'hB000_0002);
    rd(a_msg(1), d); check("R1 third out", d, 32'hC000_0003);
    rd(a_cnt(1), d); check("R3 count back to zero", d, 0);
  endtask

  task automatic t_full();
    logic [DW-1:0] d;
    for (int i = 0; i < 4; i++) wr(a_msg(2), DW'(32'h5500 + i));
    rd(a_full(2), d); check("R3 full flag", d, 1);
    wr(a_msg(2), 32'hDEAD_BEEF);
    rd(a_cnt(2), d); check("R2 count after dropped push", d, 4);
    for (int i = 0; i < 4; i++) begin
      rd(a_msg(2), d); check("R2 contents kept", d, DW'(32'h5500 + i));
    end
    rd(a_msg(2), d); check("R2 empty read returns zero", d, 0);
    rd(a_cnt(2), d); check("R2 empty read keeps count", d, 0);
    wr(a_msg(2), 32'h1234_5678);
    rd(a_msg(2), d); check("R2 queue usable after empty read", d, 32'h1234_5678);
  endtask

  task automatic t_irq();
    logic [DW-1:0] d;
    for (int u = 0; u < 4; u++) wr(a_st(u), 32'hFF);
    rd(a_st(0), d); check("R5 all cleared", d, 0);
    wr(a_en(0), 32'h01);
    rd(a_en(0), d); check("R6 enable readback", d, 32'h01);
    wr(a_msg(0), 32'h0000_0042);
    tick();
    check("R6 irq user0 raised", DW'(irq_out[0]), 1);
    check("R6 irq user1 masked", DW'(irq_out[1]), 0);
    rd(a_st(1), d); check("R4 new-word bit in other user", d, 32'h01);
    wr(a_st(0), 32'h00);
    rd(a_st(0), d); check("R5 zero write keeps bit", d, 32'h01);
    wr(a_st(0), 32'h01);
    tick();
    rd(a_st(0), d); check("R5 one write clears bit", d, 0);
    check("R6 irq user0 dropped", DW'(irq_out[0]), 0);
    rd(a_msg(0), d); check("R1 mailbox0 word", d, 32'h42);
    rd(a_st(0), d); check("R4 no not-full from non-full pop", d, 0);
  endtask

  task automatic t_notfull();
    logic [DW-1:0] d;
    for (int i = 0; i < 4; i++) wr(a_msg(3), DW'(i + 1));
    wr(a_st(2), 32'hFF);
    wr(a_en(2), 32'h80);
    tick();
    check("R6 irq user2 idle", DW'(irq_out[2]), 0);
    rd(a_msg(3), d); check("R1 mailbox3 first", d, 1);
    tick();
    rd(a_st(2), d); check("R4 not-full bit set", d, 32'h80);
    check("R6 irq user2 on not-full", DW'(irq_out[2]), 1);
    wr(a_st(2), 32'h80);
    rd(a_msg(3), d);
    tick();
    rd(a_st(2), d); check("R4 second pop raises nothing", d, 0);
    check("R6 irq user2 cleared", DW'(irq_out[2]), 0);
  endtask

  task automatic t_softreset();
    logic [DW-1:0] d;
    int waited;
    wr(a_msg(0), 32'h77);
    wr(a_en(1), 32'h03);
    tick();
    check("R6 irq user1 before soft reset", DW'(irq_out[1]), 1);
    wr(10'h010, 32'h2);
    rd(10'h010, d); check("R7 reset bit while running", d & 32'h2, 32'h2);
    rd(10'h014, d); check("R7 done low while running", d & 32'h1, 0);
    waited = 0;
    d = 0;
    while (d[0] !== 1'b1 && waited < 20) begin
      rd(10'h014, d);
      waited++;
    end
    check("R7 done returns", d & 32'h1, 1);
    rd(10'h010, d); check("R7 reset bit self-cleared", d & 32'h2, 0);
    rd(a_cnt(0), d); check("R7 queue emptied", d, 0);
    rd(a_cnt(3), d); check("R7 queue3 emptied", d, 0);
    rd(a_st(1), d);  check("R7 status cleared", d, 0);
    rd(a_en(1), d);  check("R7 enable cleared", d, 0);
    rd(a_en(2), d);  check("R7 enable2 cleared", d, 0);
    check("R7 irq lines low", DW'(irq_out), 0);
    wr(a_msg(0), 32'h99);
    rd(a_msg(0), d); check("R7 mailbox works after", d, 32'h99);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d;
    wr(a_msg(1), 32'hFFFF_FFFF);
    rd(a_msg(1), d);
    rd(10'h020, d); check("R10 hole reads zero", d, 0);
    rd(10'h3FC, d); check("R10 top reads zero", d, 0);
    rd(10'h0D0, d); check("R10 past count regs zero", d, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_irq();
    t_notfull();
    t_softreset();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule